// File: doc/BRIEF.md
# 10BASE-T Link Integrity Monitor

This block tracks whether the far end of a twisted-pair port is alive. It watches two strobes from the receive path, one for each qualified link pulse and one for each received packet, together with a 1 ms timebase tick. If neither arrives for a long stretch it declares the link failed. It declares the link good again after a packet, or after a short run of link pulses whose spacing is within limits. Pulses that arrive too soon after the last accepted pulse are discarded as noise.

The registered `link_ok` output gates the transmit path and the normal loopback path of the port. `led_link_n` drives an active-low link lamp. A link-test enable input and an active-low forced-pass strap both override the monitor and hold the link good. Pulse shape and threshold qualification happen upstream and are not part of this block.

Top module: `link_integrity_mon`

## Requirements
- R1: While `lt_en` is low, `link_ok` is 1 from the first clock edge that samples it low. It stays 1 however many ticks pass. Raising `lt_en` again starts a fresh silence window in the pass state.
- R2: In the pass state, `link_ok` falls at the clock edge that samples the LOSS_MS-th `tick_1ms`, counted since the last accepted pulse or packet, provided no accepted activity has arrived in between.
- R3: In the fail state, `link_ok` is 0, which blocks transmit and normal loopback.
- R4: In the fail state, a `pkt_strobe` sets `link_ok` to 1 at the edge that samples it.
- R5: A link pulse is accepted only if at least BLANK_MS ticks have passed since the previous accepted pulse. The first pulse after reset is always accepted. A rejected pulse has no effect: it does not count toward recovery, does not restart the silence window, and does not restart the pulse-spacing measurement.
- R6: While `force_pass_n` is low, `link_ok` is 1 from the first clock edge that samples it low.
- R7: In the fail state, RECOVER_PULSES consecutive accepted pulses bring `link_ok` to 1 at the edge of the last one. Each pulse after the first must come no more than LOSS_MS ticks after the pulse before it. An accepted pulse that comes later than that restarts the run at one.
- R8: Each accepted pulse and each packet restarts the silence window from zero.
- R9: After reset, `link_ok` is 0. The exception is when `lt_en` is low or `force_pass_n` is low during reset; then `link_ok` is 1.
- R10: `led_link_n` is always the inverse of `link_ok`, so the lamp is lit (low) while the link is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1ms | input | 1 | One-cycle strobe once per millisecond |
| lt_en | input | 1 | Link test enable, active high |
| force_pass_n | input | 1 | Forced link-pass strap, active low |
| lp_strobe | input | 1 | One-cycle strobe per received link pulse |
| pkt_strobe | input | 1 | One-cycle strobe per received valid packet |
| link_ok | output | 1 | Link good; gates transmit and loopback |
| led_link_n | output | 1 | Link lamp, active low |

## Verification
The embedded properties check the following on every cycle: the two overrides force the link good, a packet recovers a failed link, a too-early pulse leaves a failed link down, the silence timeout fires on the exact tick, and the counters stay in range. The bench sweeps the gap between two recovery pulses over every value from zero to past the loss limit. It also shows that a discarded pulse neither restarts the silence window nor the spacing measurement, that the silence window restarts on accepted activity, and that reset lands in the correct state. These effects span many cycles, so only these scenarios reveal them.

// File: rtl/lim_pkg.sv
package lim_pkg;
  typedef enum logic {
    LINK_FAIL = 1'b0,
    LINK_PASS = 1'b1
  } link_state_e;
endpackage

// File: rtl/lim_ms_counter.sv
// Saturating millisecond counter with synchronous clear.
module lim_ms_counter #(
  parameter int MAX_VAL  = 65,
  parameter int INIT_VAL = 0,
  parameter int W        = $clog2(MAX_VAL + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX_W  = W'(MAX_VAL);
  localparam logic [W-1:0] INIT_W = W'(INIT_VAL);

  always_ff @(posedge clk) begin
    if (rst)                       cnt <= INIT_W;
    else if (clr)                  cnt <= '0;
    else if (tick && cnt != MAX_W) cnt <= cnt + 1'b1;
  end

  // R2: counter never runs past its ceiling
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAX_W);
endmodule

// File: rtl/lim_recover.sv
// Counts consecutive accepted link pulses while the link is down.
module lim_recover #(
  parameter int NEED = 2,
  parameter int W    = $clog2(NEED + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic pulse_acc,
  input  logic spaced_ok,
  output logic hit
);
  localparam logic [W-1:0] NEED_W = W'(NEED);
  localparam logic [W-1:0] ONE_W  = W'(1);

  logic [W-1:0] run_cnt;
  logic [W-1:0] run_nxt;

  always_comb begin
    if (!spaced_ok)            run_nxt = ONE_W;
    else if (run_cnt >= NEED_W) run_nxt = NEED_W;
    else                       run_nxt = run_cnt + 1'b1;
    hit = pulse_acc && (run_nxt >= NEED_W);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)     run_cnt <= '0;
    else if (pulse_acc) run_cnt <= run_nxt;
  end

  // R7: the run length stays within the required count
  a_r7_run_bound: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= NEED_W);
endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon
  import lim_pkg::*;
#(
  parameter int LOSS_MS        = 65,
  parameter int BLANK_MS       = 4,
  parameter int RECOVER_PULSES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic lt_en,
  input  logic force_pass_n,
  input  logic lp_strobe,
  input  logic pkt_strobe,
  output logic link_ok,
  output logic led_link_n
);
  localparam int CW = $clog2(LOSS_MS + 2);
  localparam int SPACE_MAX = LOSS_MS + 1;
  localparam logic [CW-1:0] LOSS_W   = CW'(LOSS_MS);
  localparam logic [CW-1:0] LOSS_M1  = CW'(LOSS_MS - 1);
  localparam logic [CW-1:0] BLANK_W  = CW'(BLANK_MS);

  link_state_e state_q, state_d;
  logic        led_q;
  logic        override;
  logic        pulse_acc;
  logic        activity;
  logic        spaced_ok;
  logic        loss_hit;
  logic        rec_hit;
  logic [CW-1:0] silence_cnt;
  logic [CW-1:0] space_cnt;

  assign override  = !lt_en || !force_pass_n;
  assign pulse_acc = lp_strobe && (space_cnt >= BLANK_W);
  assign activity  = pkt_strobe || pulse_acc;
  assign spaced_ok = (space_cnt <= LOSS_W);
  assign loss_hit  = tick_1ms && !activity && (silence_cnt == LOSS_M1);

  // ticks since last accepted pulse or packet
  lim_ms_counter #(.MAX_VAL(LOSS_MS), .INIT_VAL(0), .W(CW)) u_silence (
    .clk  (clk),
    .rst  (rst),
    .clr  (override || activity),
    .tick (tick_1ms),
    .cnt  (silence_cnt)
  );

  // ticks since last accepted link pulse; starts saturated
  lim_ms_counter #(.MAX_VAL(SPACE_MAX), .INIT_VAL(SPACE_MAX), .W(CW)) u_space (
    .clk  (clk),
    .rst  (rst),
    .clr  (pulse_acc),
    .tick (tick_1ms),
    .cnt  (space_cnt)
  );

  lim_recover #(.NEED(RECOVER_PULSES)) u_recover (
    .clk       (clk),
    .rst       (rst),
    .clr       (override || state_q == LINK_PASS),
    .pulse_acc (pulse_acc),
    .spaced_ok (spaced_ok),
    .hit       (rec_hit)
  );

  always_comb begin
    state_d = state_q;
    if (override) begin
      state_d = LINK_PASS;
    end else begin
      case (state_q)
        LINK_PASS: if (loss_hit) state_d = LINK_FAIL;
        LINK_FAIL: if (pkt_strobe || rec_hit) state_d = LINK_PASS;
        default:   state_d = LINK_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= override ? LINK_PASS : LINK_FAIL;
      led_q   <= override ? 1'b0 : 1'b1;
    end else begin
      state_q <= state_d;
      led_q   <= (state_d != LINK_PASS);
    end
  end

  assign link_ok    = (state_q == LINK_PASS);
  assign led_link_n = led_q;

  // R1: link test disabled holds the link good
  a_r1_test_off: assert property (@(posedge clk) disable iff (rst)
    !lt_en |=> link_ok);

  // R6: forced-pass strap holds the link good
  a_r6_forced: assert property (@(posedge clk) disable iff (rst)
    !force_pass_n |=> link_ok);

  // R4: packet recovers a failed link
  a_r4_pkt_recover: assert property (@(posedge clk) disable iff (rst)
    (!link_ok && !override && pkt_strobe) |=> link_ok);

  // R5: a pulse inside the blanking window cannot bring the link up
  a_r5_blank: assert property (@(posedge clk) disable iff (rst)
    (!link_ok && !override && !pkt_strobe && (space_cnt < BLANK_W)) |=> !link_ok);

  // R2: the final silent tick drops the link
  a_r2_timeout: assert property (@(posedge clk) disable iff (rst)
    (link_ok && !override && tick_1ms && !pkt_strobe && !lp_strobe
     && silence_cnt == LOSS_M1) |=> !link_ok);

  // R10: lamp and link flag always agree
  a_r10_led: assert property (@(posedge clk) disable iff (rst)
    led_link_n != link_ok);
endmodule

// File: tb/link_integrity_mon_tb.sv
module link_integrity_mon_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOSS  = 12;
  localparam int BLANK = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1ms = 1'b0;
  logic lt_en = 1'b1;
  logic force_pass_n = 1'b1;
  logic lp_strobe = 1'b0;
  logic pkt_strobe = 1'b0;
  logic link_ok, led_link_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_integrity_mon #(.LOSS_MS(LOSS), .BLANK_MS(BLANK), .RECOVER_PULSES(2)) u_dut (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .lt_en(lt_en),
    .force_pass_n(force_pass_n), .lp_strobe(lp_strobe), .pkt_strobe(pkt_strobe),
    .link_ok(link_ok), .led_link_n(led_link_n)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic exp, input string req);
    checks++;
    if (link_ok !== exp) begin
      errors++;
      $display("FAIL %s link_ok actual %0b expected %0b", req, link_ok, exp);
    end
    checks++;
    if (led_link_n !== !exp) begin
      errors++;
      $display("FAIL R10 led_link_n actual %0b expected %0b (%s)", led_link_n, !exp, req);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_1ms = 1'b1;
      @(negedge clk) tick_1ms = 1'b0;
    end
  endtask

  task automatic pulse();
    @(negedge clk) lp_strobe = 1'b1;
    @(negedge clk) lp_strobe = 1'b0;
  endtask

  task automatic packet();
    @(negedge clk) pkt_strobe = 1'b1;
    @(negedge clk) pkt_strobe = 1'b0;
  endtask

  initial begin
    // R9: reset state, plain and overridden
    do_reset();
    chk(1'b0, "R9 reset fail");
    force_pass_n = 1'b0;
    do_reset();
    force_pass_n = 1'b1;
    chk(1'b1, "R9 reset forced");
    lt_en = 1'b0;
    do_reset();
    chk(1'b1, "R9 reset test off");
    lt_en = 1'b1;
    @(negedge clk);
    chk(1'b1, "R1 release keeps pass");
    ticks(LOSS - 1);
    chk(1'b1, "R1 fresh window");
    ticks(1);
    chk(1'b0, "R2 timeout after release");

    // R4: packet recovers; R2 exact timeout
    do_reset();
    chk(1'b0, "R3 fail blocks");
    packet();
    chk(1'b1, "R4 packet recovers");
    ticks(LOSS - 1);
    chk(1'b1, "R2 one tick early");
    ticks(1);
    chk(1'b0, "R2 timeout");

    // R8: accepted pulse restarts silence
    packet();
    ticks(5);
    pulse();
    ticks(LOSS - 1);
    chk(1'b1, "R8 pulse restarts window");
    ticks(1);
    chk(1'b0, "R8 timeout after pulse");
    // R8: packet restarts silence
    packet();
    ticks(7);
    packet();
    ticks(LOSS - 1);
    chk(1'b1, "R8 packet restarts window");

    // R5: rejected pulse does not restart silence
    do_reset();
    packet();
    ticks(2);
    pulse();
    ticks(1);
    pulse();
    ticks(LOSS - 2);
    chk(1'b1, "R5 before timeout");
    ticks(1);
    chk(1'b0, "R5 rejected pulse ignored by silence");

    // R7/R5: sweep gap between two recovery pulses
    for (int g = 0; g <= LOSS + 2; g++) begin
      do_reset();
      pulse();
      chk(1'b0, "R7 single pulse stays down");
      ticks(g);
      pulse();
      if (g < BLANK) begin
        chk(1'b0, "R5 early pulse ignored");
        ticks(BLANK);
        pulse();
        chk((g + BLANK) <= LOSS, "R5 spacing kept from accepted pulse");
      end else if (g <= LOSS) begin
        chk(1'b1, "R7 two spaced pulses recover");
      end else begin
        chk(1'b0, "R7 late pulse restarts run");
        ticks(BLANK);
        pulse();
        chk(1'b1, "R7 run after restart");
      end
    end

    // R1: link test off holds pass through long silence
    do_reset();
    lt_en = 1'b0;
    @(negedge clk);
    chk(1'b1, "R1 test off");
    ticks(LOSS + 5);
    chk(1'b1, "R1 no timeout when off");
    lt_en = 1'b1;

    // R6: forced strap
    do_reset();
    force_pass_n = 1'b0;
    @(negedge clk);
    chk(1'b1, "R6 forced pass");
    ticks(LOSS + 5);
    chk(1'b1, "R6 no timeout when forced");
    force_pass_n = 1'b1;
    ticks(LOSS);
    chk(1'b0, "R2 timeout after strap release");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule